// File: doc/BRIEF.md
# FIFO Fully Associative Victim Buffer

This block is a small, fully associative holding area for blocks recently thrown out of a first-level cache. It sits between the first level and the second level and tracks only block addresses and dirty bits. Block data is not stored. After a first-level miss, the first level presents the missing block address in `req_addr`. In the same cycle it presents the block it would evict through `ev_valid`, `ev_addr` and `ev_dirty`. The buffer answers in that same cycle and updates its state at the next clock edge.

On a hit, the matching entry is handed back to the first level together with its dirty bit. The first level's evicted block takes that entry's slot. On a miss, the evicted block is stored. If every slot is in use, the entry that has been in the buffer longest is pushed out. A pushed-out entry is offered to the second level on `l2_wr_valid`/`l2_wr_addr` only when it is dirty; a clean one is dropped. The `DEPTH` parameter sets the number of slots, from 0 to 4. With 0 slots, every lookup misses and a dirty eviction goes straight to the second level. Four counters record hits and misses, separated into reads and writes.

Top module: `victim_fifo_buf`

## Requirements
- R1: After reset the buffer holds no entries and all four counters read zero, so the first lookup misses.
- R2: When `req_valid` is high, `hit` is high in the same cycle exactly when a stored entry's full block address equals `req_addr`. `hit_dirty` then gives that entry's dirty bit.
- R3: On a hit with `ev_valid` high, the matched entry is replaced by `ev_addr`/`ev_dirty`, and nothing is sent to the second level. A later lookup of the old address misses, and a lookup of `ev_addr` hits with the dirty bit that was supplied.
- R4: On a hit with `ev_valid` low, the matched entry is removed, which frees its slot.
- R5: On a miss with `ev_valid` high and a free slot, the eviction is stored and `l2_wr_valid` stays low.
- R6: On a miss with `ev_valid` high and all slots in use, the oldest entry is pushed out. `l2_wr_valid` is high in that cycle with `l2_wr_addr` equal to the pushed-out address only if that entry is dirty; a clean entry produces no write.
- R7: Age is measured from the time an entry was placed in the buffer. An entry placed by a hit swap counts as the newest, and removing an entry keeps the relative order of the remaining entries.
- R8: With `DEPTH` = 0, `hit` is always low. A valid dirty eviction drives `l2_wr_valid` with `l2_wr_addr` = `ev_addr` in the same cycle, and a clean eviction is dropped.
- R9: Each cycle with `req_valid` high adds one to exactly one counter. The counter is selected by hit or miss and by `req_write` (1 = write, 0 = read): `rd_hits`, `rd_misses`, `wr_hits` or `wr_misses`.
- R10: While `req_valid` is low, the eviction inputs are ignored. No entry changes, no counter moves, and `l2_wr_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request after a first-level miss |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Block address to look up |
| ev_valid | input | 1 | First-level eviction present |
| ev_addr | input | ADDR_W | Evicted block address |
| ev_dirty | input | 1 | Evicted block dirty bit |
| hit | output | 1 | Lookup matched a stored entry |
| hit_dirty | output | 1 | Dirty bit of the matched entry |
| l2_wr_valid | output | 1 | Dirty block pushed to second level |
| l2_wr_addr | output | ADDR_W | Address of the pushed block |
| rd_hits | output | CNT_W | Read hit count |
| rd_misses | output | CNT_W | Read miss count |
| wr_hits | output | CNT_W | Write hit count |
| wr_misses | output | CNT_W | Write miss count |

## Verification
The bench builds two copies of the block with 16-bit addresses and 8-bit counters, and both receive the same stimulus. One copy has `DEPTH` = 4. This brings the full-buffer ejection order within reach, along with swaps into a full buffer and removals that free slots in the middle of the order. The other copy has `DEPTH` = 0 and shows, at every step, that dirty evictions pass straight through and clean ones are dropped.

// File: rtl/victim_fifo_buf.sv
module victim_fifo_buf #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_dirty,
  output logic              hit,
  output logic              hit_dirty,
  output logic              l2_wr_valid,
  output logic [ADDR_W-1:0] l2_wr_addr,
  output logic [CNT_W-1:0]  rd_hits,
  output logic [CNT_W-1:0]  rd_misses,
  output logic [CNT_W-1:0]  wr_hits,
  output logic [CNT_W-1:0]  wr_misses
);
  localparam bit BYPASS = (DEPTH == 0);
  localparam int SLOTS  = BYPASS ? 1 : DEPTH;
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int AGE_W  = $clog2(SLOTS + 1);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(SLOTS - 1);

  logic [SLOTS-1:0]  vld, dty, match;
  logic [ADDR_W-1:0] tag [SLOTS];
  logic [AGE_W-1:0]  age [SLOTS];
  logic [IDX_W-1:0]  hit_idx, free_idx, old_idx, tgt_idx;
  logic              full, any_match;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      match[i] = !BYPASS && vld[i] && (tag[i] == req_addr);
      if (match[i]) hit_idx = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
      if (vld[i] && age[i] == OLDEST) old_idx = IDX_W'(i);
    end
  end

  assign any_match   = |match;
  assign full        = &vld;
  assign hit         = req_valid && any_match;
  assign hit_dirty   = hit && |(match & dty);
  assign tgt_idx     = any_match ? hit_idx : (full ? old_idx : free_idx);
  assign l2_wr_valid = BYPASS ? (req_valid && ev_valid && ev_dirty)
                              : (req_valid && !any_match && ev_valid && full && dty[old_idx]);
  assign l2_wr_addr  = BYPASS ? ev_addr : tag[old_idx];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        dty[g] <= 1'b0;
        tag[g] <= '0;
        age[g] <= '0;
      end else if (req_valid && !BYPASS) begin
        if (any_match) begin
          if (hit_idx == IDX_W'(g)) begin
            vld[g] <= ev_valid;
            dty[g] <= ev_dirty;
            tag[g] <= ev_addr;
            age[g] <= '0;
          end else if (vld[g]) begin
            if (ev_valid && age[g] < age[hit_idx]) age[g] <= age[g] + 1'b1;
            else if (!ev_valid && age[g] > age[hit_idx]) age[g] <= age[g] - 1'b1;
          end
        end else if (ev_valid) begin
          if (tgt_idx == IDX_W'(g)) begin
            vld[g] <= 1'b1;
            dty[g] <= ev_dirty;
            tag[g] <= ev_addr;
            age[g] <= '0;
          end else if (vld[g]) begin
            age[g] <= age[g] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hits   <= '0;
      rd_misses <= '0;
      wr_hits   <= '0;
      wr_misses <= '0;
    end else if (req_valid) begin
      case ({req_write, any_match})
        2'b01:   rd_hits   <= rd_hits + 1'b1;
        2'b00:   rd_misses <= rd_misses + 1'b1;
        2'b11:   wr_hits   <= wr_hits + 1'b1;
        default: wr_misses <= wr_misses + 1'b1;
      endcase
    end
  end

  assert_one_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_hit_needs_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $countones(vld) != 0);

  assert_no_swap_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ev_valid) |=> $countones(vld) == $past($countones(vld)));

  assert_free_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ev_valid) |=> $countones(vld) == $past($countones(vld)) - 1);

  assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_match && ev_valid && !full && !BYPASS)
      |=> $countones(vld) == $past($countones(vld)) + 1);

  assert_stay_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_match && ev_valid && full && !BYPASS) |=> &vld);

  assert_rd_hit_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !req_write) |=> rd_hits == $past(rd_hits) + 1'b1);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(vld) && $stable(dty) && $stable(wr_misses) && $stable(rd_misses));
endmodule

// File: tb/victim_fifo_buf_tb.sv
module victim_fifo_buf_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ev_valid = 1'b0, ev_dirty = 1'b0;
  logic [15:0] req_addr = '0, ev_addr = '0;
  logic hit, hit_dirty, l2v;
  logic [15:0] l2a;
  logic [7:0] rh, rm, wh, wm;
  logic bhit, bhd, bl2v;
  logic [15:0] bl2a;
  logic [7:0] brh, brm, bwh, bwm;
  int checks = 0, fails = 0;
  int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0;

  always #4 clk = ~clk;

  victim_fifo_buf #(.ADDR_W(16), .DEPTH(4), .CNT_W(8)) u_dut (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .ev_valid, .ev_addr, .ev_dirty,
    .hit, .hit_dirty, .l2_wr_valid(l2v), .l2_wr_addr(l2a),
    .rd_hits(rh), .rd_misses(rm), .wr_hits(wh), .wr_misses(wm));

  victim_fifo_buf #(.ADDR_W(16), .DEPTH(0), .CNT_W(8)) u_bypass (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .ev_valid, .ev_addr, .ev_dirty,
    .hit(bhit), .hit_dirty(bhd), .l2_wr_valid(bl2v), .l2_wr_addr(bl2a),
    .rd_hits(brh), .rd_misses(brm), .wr_hits(bwh), .wr_misses(bwm));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [15:0] a, input logic w, input logic ev, input logic [15:0] ea,
                    input logic ed, input logic xh, input logic xhd, input logic xl2,
                    input logic [15:0] xl2a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    ev_valid = ev; ev_addr = ea; ev_dirty = ed;
    #1;
    chk({tag, " hit"}, hit, xh);
    if (xh) chk({tag, " hit_dirty"}, hit_dirty, xhd);
    chk({tag, " l2 valid"}, l2v, xl2);
    if (xl2) chk({tag, " l2 addr"}, l2a, xl2a);
    chk("R8 bypass hit", bhit, 0);
    chk("R8 bypass l2 valid", bl2v, ev && ed);
    if (ev && ed) chk("R8 bypass l2 addr", bl2a, ea);
    if (w) begin if (xh) e_wh++; else e_wm++; end
    else begin if (xh) e_rh++; else e_rm++; end
    @(posedge clk); #1;
    req_valid = 1'b0; ev_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 rd_hits", rh, 0); chk("R1 rd_misses", rm, 0);
    chk("R1 wr_hits", wh, 0); chk("R1 wr_misses", wm, 0);
    op(16'h0010, 0, 0, 0, 0, 0, 0, 0, 0, "R1 first lookup");
  endtask

  task automatic t_fill;
    op(16'hF001, 0, 1, 16'h0100, 1, 0, 0, 0, 0, "R5 fill1");
    op(16'hF002, 1, 1, 16'h0200, 0, 0, 0, 0, 0, "R5 fill2");
    op(16'hF003, 0, 1, 16'h0300, 1, 0, 0, 0, 0, "R5 fill3");
    op(16'hF004, 1, 1, 16'h0400, 0, 0, 0, 0, 0, "R5 fill4");
  endtask

  task automatic t_swap;
    op(16'h0200, 1, 1, 16'h0500, 1, 1, 0, 0, 0, "R3 swap hit");
    op(16'h0200, 0, 0, 0, 0, 0, 0, 0, 0, "R3 old address gone");
    op(16'h0500, 0, 0, 0, 0, 1, 1, 0, 0, "R4 remove swapped entry");
    op(16'hF005, 0, 1, 16'h0500, 1, 0, 0, 0, 0, "R4 freed slot refilled");
  endtask

  task automatic t_eject;
    op(16'hF006, 1, 1, 16'h0600, 0, 0, 0, 1, 16'h0100, "R6 eject oldest dirty");
    op(16'hF007, 0, 1, 16'h0700, 1, 0, 0, 1, 16'h0300, "R6 eject second dirty");
    op(16'hF008, 0, 1, 16'h0800, 0, 0, 0, 0, 0, "R6 clean ejection dropped");
    op(16'hF009, 1, 1, 16'h0900, 1, 0, 0, 1, 16'h0500, "R7 refilled entry ejected in order");
  endtask

  task automatic t_idle;
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = 16'h0AAA; ev_dirty = 1'b1; req_addr = 16'h0600;
    #1 chk("R10 idle l2 valid", l2v, 0);
    chk("R10 idle hit", hit, 0);
    @(posedge clk); #1 ev_valid = 1'b0;
    chk("R10 idle counters", {rh, rm, wh, wm}, {8'(e_rh), 8'(e_rm), 8'(e_wh), 8'(e_wm)});
    op(16'h0AAA, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle eviction not stored");
  endtask

  task automatic t_order;
    op(16'h0600, 0, 0, 0, 0, 1, 0, 0, 0, "R7 remove oldest");
    op(16'hF00A, 1, 1, 16'h0B00, 1, 0, 0, 0, 0, "R7 refill after removal");
    op(16'hF00B, 0, 1, 16'h0C00, 0, 0, 0, 1, 16'h0700, "R7 order kept after removal");
    op(16'h0900, 1, 1, 16'h0D00, 0, 1, 1, 0, 0, "R3 swap in full buffer");
    op(16'hF00C, 0, 1, 16'h0E00, 0, 0, 0, 0, 0, "R7 clean oldest dropped");
    op(16'hF00D, 0, 1, 16'h0F00, 0, 0, 0, 1, 16'h0B00, "R7 next oldest ejected");
    op(16'h0D00, 0, 0, 0, 0, 1, 0, 0, 0, "R3 swapped entry lookup");
  endtask

  task automatic t_counts;
    chk("R9 rd_hits", rh, e_rh); chk("R9 rd_misses", rm, e_rm);
    chk("R9 wr_hits", wh, e_wh); chk("R9 wr_misses", wm, e_wm);
    chk("R8 bypass read misses", brm, e_rh + e_rm);
    chk("R8 bypass write misses", bwm, e_wh + e_wm);
    chk("R8 bypass hits", {brh, bwh}, 0);
  endtask

  initial begin
    t_reset;
    t_fill;
    t_swap;
    t_eject;
    t_idle;
    t_order;
    t_counts;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule